// File: doc/BRIEF.md
# Bus Master Tenure Controller

This block is the ownership state machine that sits inside a bus master in front of a shared bus. It raises a bus request while the master has work pending, takes the bus when an external arbiter grants it and the bus is quiet, and gives a permission strobe that starts each transfer. When the arbiter takes the grant away, the block decides when the bus is handed back.

A transfer that is in progress always finishes before the bus is released. A line fill split into single long-word beats counts as one transfer. An indivisible read-modify-write sequence (the lock flag) can keep the bus past a grant removal. This depends on a severity input that is sampled on the edge where the grant falls. The block watches the transfer-start strobes of other masters and the shared busy line, so it never starts a cycle on top of someone else's tenure. All state moves only on clock edges where the clock-enable qualifier is high.

Top module: `bus_tenure_ctrl`

## Requirements
- R1: State advances only on rising edges where `clk_en_i` is 1. An edge with `clk_en_i` low leaves the tenure state, the beat count and the captured grant unchanged.
- R2: `bus_req_o` equals `req_pend_i` at all times, in every state and whatever `grant_i` and `busy_ext_i` are.
- R3: While the block does not own the bus, `start_o` and `busy_o` are 1 in the same cycle in which `req_pend_i` and `grant_i` are both 1 and the bus is free. On the next enabled edge the block owns the bus with a transfer in progress, and `start_o` returns to 0.
- R4: The bus is free only when `busy_ext_i` is 0 and no foreign cycle is open. A foreign cycle opens on an enabled edge with `ext_ts_i` = 1 and closes on an enabled edge with any termination strobe. While the bus is not free, `start_o` stays 0.
- R5: If `grant_i` is 0 on the enabled edge that ends the current transfer, `busy_o` is 0 after that edge. If the grant falls only later, the block parks with `busy_o` = 1 and releases on the first enabled edge that sees `grant_i` = 0.
- R6: A transfer started with `line_inh_i` = 1 ends only on the 4th `term_ok_i` (LINE_BEATS). `busy_o` stays 1 through the earlier beats even with the grant removed. `term_err_i` or `term_retry_i` ends the transfer at once.
- R7: In a locked sequence (`locked_i` = 1), if `sever_i` is 1 on the edge where the grant falls, the bus is released when the current transfer ends.
- R8: In a locked sequence, if `sever_i` is 0 on the edge where the grant falls, the block keeps the bus and may start further transfers without a grant. It releases on the first enabled edge while parked with `locked_i` = 0.
- R9: After a release with `req_pend_i` still 1, `start_o` rises again as soon as `grant_i` returns.
- R10: After reset, `busy_o` and `start_o` are 0 while `grant_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Qualifies which rising edges advance state |
| req_pend_i | input | 1 | Internal request pending |
| grant_i | input | 1 | Grant from the external arbiter |
| sever_i | input | 1 | Grant-removal severity for locked sequences |
| locked_i | input | 1 | Current sequence is locked |
| line_inh_i | input | 1 | Transfer being started is a four-beat burst-inhibited line |
| ext_ts_i | input | 1 | Transfer-start strobe seen from any other master |
| busy_ext_i | input | 1 | Busy line held by another master |
| term_ok_i | input | 1 | Normal termination of a beat |
| term_err_i | input | 1 | Error termination |
| term_retry_i | input | 1 | Retry termination |
| bus_req_o | output | 1 | Bus request to the arbiter |
| busy_o | output | 1 | Bus held by this master |
| start_o | output | 1 | Permission to start a transfer |

## Verification
The hard case is when a transfer ends on the same enabled edge where the grant falls, or where a locked sequence samples the severity input. In that cycle the release decision must use the new grant level and the just-formed hold. The bench provokes this by lowering `grant_i` just before the terminating edge, and separately just after it. It then judges `busy_o` one edge later against the R5 timing. The locked runs drop the grant a cycle before termination, with `sever_i` at each level, and check whether ownership survives the terminating edge.

// File: rtl/bus_tenure_pkg.sv
package bus_tenure_pkg;
  typedef enum logic [1:0] {
    TEN_IDLE = 2'd0,
    TEN_XFER = 2'd1,
    TEN_PARK = 2'd2
  } tenure_e;
endpackage

// File: rtl/ext_cycle_track.sv
module ext_cycle_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic track_i,
  input  logic ts_i,
  input  logic term_i,
  output logic open_o
);
  logic open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
    end else if (en_i) begin
      if (!track_i)    open_q <= 1'b0;
      else if (ts_i)   open_q <= 1'b1;
      else if (term_i) open_q <= 1'b0;
    end
  end

  assign open_o = open_q;

  AST_EXT_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && open_q && term_i && !ts_i) |=> !open_q); // R4
endmodule

// File: rtl/line_beat_cnt.sv
module line_beat_cnt #(
  parameter int unsigned BEATS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clear_i,
  input  logic step_i,
  output logic last_o
);
  localparam int unsigned CW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (en_i) begin
      if (clear_i)      cnt_q <= '0;
      else if (step_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign last_o = (cnt_q == LAST);

  AST_BEAT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == $past(cnt_q))); // R1
endmodule

// File: rtl/lock_hold.sv
module lock_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic own_i,
  input  logic grant_i,
  input  logic locked_i,
  input  logic sever_i,
  output logic hold_o
);
  logic grant_q;
  logic hold_q;
  logic drop_w;
  logic hold_set_w;

  assign drop_w     = own_i && grant_q && !grant_i;
  assign hold_set_w = drop_w && locked_i && !sever_i;
  // soft removal inside a lock holds the bus until the lock ends
  assign hold_o     = (hold_q && locked_i) || hold_set_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= 1'b0;
      hold_q  <= 1'b0;
    end else if (en_i) begin
      grant_q <= grant_i;
      if (!own_i || !locked_i) hold_q <= 1'b0;
      else if (hold_set_w)     hold_q <= 1'b1;
    end
  end

  AST_HOLD_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !locked_i) |=> !hold_q); // R8
  AST_GRANT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (grant_q == $past(grant_q))); // R1
endmodule

// File: rtl/bus_tenure_ctrl.sv
module bus_tenure_ctrl
  import bus_tenure_pkg::*;
#(
  parameter int unsigned LINE_BEATS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_en_i,
  input  logic req_pend_i,
  input  logic grant_i,
  input  logic sever_i,
  input  logic locked_i,
  input  logic line_inh_i,
  input  logic ext_ts_i,
  input  logic busy_ext_i,
  input  logic term_ok_i,
  input  logic term_err_i,
  input  logic term_retry_i,
  output logic bus_req_o,
  output logic busy_o,
  output logic start_o
);
  tenure_e st_q, st_d;
  logic    line_q;
  logic    term_any_w;
  logic    ext_open_w;
  logic    bus_free_w;
  logic    last_beat_w;
  logic    hold_w;
  logic    done_w;
  logic    release_w;
  logic    own_w;

  assign term_any_w = term_ok_i | term_err_i | term_retry_i;
  assign own_w      = (st_q != TEN_IDLE);
  assign bus_free_w = !busy_ext_i && !ext_open_w && !ext_ts_i;

  ext_cycle_track u_ext (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (clk_en_i),
    .track_i (st_q == TEN_IDLE),
    .ts_i    (ext_ts_i),
    .term_i  (term_any_w),
    .open_o  (ext_open_w)
  );

  line_beat_cnt #(.BEATS(LINE_BEATS)) u_beat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (clk_en_i),
    .clear_i (start_o),
    .step_i  ((st_q == TEN_XFER) && line_q && term_ok_i),
    .last_o  (last_beat_w)
  );

  lock_hold u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (clk_en_i),
    .own_i    (own_w),
    .grant_i  (grant_i),
    .locked_i (locked_i),
    .sever_i  (sever_i),
    .hold_o   (hold_w)
  );

  always_comb begin
    unique case (st_q)
      TEN_IDLE: start_o = req_pend_i && grant_i && bus_free_w;
      TEN_PARK: start_o = req_pend_i && (grant_i || hold_w);
      default:  start_o = 1'b0;
    endcase
  end

  assign done_w    = (st_q == TEN_XFER) &&
                     (term_err_i || term_retry_i ||
                      (term_ok_i && (!line_q || last_beat_w)));
  assign release_w = !grant_i && !hold_w;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      TEN_IDLE: if (start_o) st_d = TEN_XFER;
      TEN_XFER: if (done_w)  st_d = release_w ? TEN_IDLE : TEN_PARK;
      TEN_PARK: begin
        if (start_o)        st_d = TEN_XFER;
        else if (release_w) st_d = TEN_IDLE;
      end
      default: st_d = TEN_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TEN_IDLE;
      line_q <= 1'b0;
    end else if (clk_en_i) begin
      st_q <= st_d;
      if (start_o) line_q <= line_inh_i;
    end
  end

  assign bus_req_o = req_pend_i;
  assign busy_o    = own_w || start_o;

  AST_STATE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> (st_q == $past(st_q))); // R1
  AST_START_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && start_o) |=> (st_q == TEN_XFER)); // R3
  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TEN_IDLE && busy_ext_i) |-> !busy_o); // R4
  AST_LINE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && st_q == TEN_XFER && line_q && term_ok_i && !last_beat_w &&
     !term_err_i && !term_retry_i) |=> (st_q == TEN_XFER)); // R6
endmodule

// File: tb/sim_bus_tenure_ctrl.sv
`timescale 1ns/100ps
module sim_bus_tenure_ctrl;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clk_en_i, req_pend_i, grant_i, sever_i, locked_i, line_inh_i;
  logic ext_ts_i, busy_ext_i, term_ok_i, term_err_i, term_retry_i;
  logic bus_req_o, busy_o, start_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk_i = ~clk_i;

  bus_tenure_ctrl u0 (.*);

  // {req, grant, busy_ext, exp_req, exp_start}
  localparam logic [4:0] VEC [8] = '{
    5'b000_0_0, 5'b001_0_0, 5'b010_0_0, 5'b011_0_0,
    5'b100_1_0, 5'b101_1_0, 5'b110_1_1, 5'b111_1_0
  };

  task automatic chk(input string rq, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle_inputs();
    clk_en_i = 1'b1; req_pend_i = 1'b0; grant_i = 1'b0; sever_i = 1'b0;
    locked_i = 1'b0; line_inh_i = 1'b0; ext_ts_i = 1'b0; busy_ext_i = 1'b0;
    term_ok_i = 1'b0; term_err_i = 1'b0; term_retry_i = 1'b0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_ni = 1'b0;
    step(); step();
    rst_ni = 1'b1;
    step();
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10 reset state
    chk("R10 busy", busy_o, 1'b0);
    chk("R10 start", start_o, 1'b0);
    chk("R2 req idle", bus_req_o, 1'b0);

    // table walk with clock enable low: no state motion (R1, R2, R3, R4)
    clk_en_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      {req_pend_i, grant_i, busy_ext_i} = VEC[i][4:2];
      #1;
      chk("R2 req mirror", bus_req_o, VEC[i][1]);
      chk("R3/R4 start", start_o, VEC[i][0]);
      step();
      chk("R1 no advance", start_o, VEC[i][0]);
    end
    busy_ext_i = 1'b0; req_pend_i = 1'b1; grant_i = 1'b1;
    clk_en_i = 1'b1;
    step();
    chk("R3 owned start low", start_o, 1'b0);
    chk("R3 owned busy", busy_o, 1'b1);

    // R5 grant low at completion edge, then R9 re-request
    do_reset();
    req_pend_i = 1'b1; grant_i = 1'b1; #1;
    chk("R3 same-cycle start", start_o, 1'b1);
    chk("R3 same-cycle busy", busy_o, 1'b1);
    step();
    grant_i = 1'b0; term_ok_i = 1'b1;
    step();
    term_ok_i = 1'b0;
    chk("R5 release at end", busy_o, 1'b0);
    chk("R2 req held", bus_req_o, 1'b1);
    grant_i = 1'b1; #1;
    chk("R9 restart", start_o, 1'b1);

    // R5 grant drops after completion edge
    do_reset();
    req_pend_i = 1'b1; grant_i = 1'b1;
    step();
    req_pend_i = 1'b0; term_ok_i = 1'b1;
    step();
    term_ok_i = 1'b0;
    chk("R5 parked", busy_o, 1'b1);
    grant_i = 1'b0;
    step();
    chk("R5 late release", busy_o, 1'b0);

    // R6 line transfer
    do_reset();
    req_pend_i = 1'b1; grant_i = 1'b1; line_inh_i = 1'b1;
    step();
    req_pend_i = 1'b0; grant_i = 1'b0; line_inh_i = 1'b0; term_ok_i = 1'b1;
    for (int b = 1; b < 4; b++) begin
      step();
      chk("R6 beat hold", busy_o, 1'b1);
    end
    step();
    chk("R6 fourth beat release", busy_o, 1'b0);
    term_ok_i = 1'b0;
    req_pend_i = 1'b1; grant_i = 1'b1; line_inh_i = 1'b1;
    step();
    req_pend_i = 1'b0; grant_i = 1'b0; line_inh_i = 1'b0; term_err_i = 1'b1;
    step();
    term_err_i = 1'b0;
    chk("R6 error ends line", busy_o, 1'b0);

    // R7 locked, severe removal
    do_reset();
    req_pend_i = 1'b1; grant_i = 1'b1; locked_i = 1'b1; sever_i = 1'b1;
    step();
    req_pend_i = 1'b0; grant_i = 1'b0;
    step();
    chk("R7 hold to cycle end", busy_o, 1'b1);
    term_ok_i = 1'b1;
    step();
    term_ok_i = 1'b0;
    chk("R7 release", busy_o, 1'b0);

    // R8 locked, soft removal
    do_reset();
    req_pend_i = 1'b1; grant_i = 1'b1; locked_i = 1'b1; sever_i = 1'b0;
    step();
    req_pend_i = 1'b0; grant_i = 1'b0;
    step();
    term_ok_i = 1'b1;
    step();
    term_ok_i = 1'b0;
    chk("R8 kept", busy_o, 1'b1);
    req_pend_i = 1'b1; #1;
    chk("R8 start without grant", start_o, 1'b1);
    step();
    req_pend_i = 1'b0; term_ok_i = 1'b1;
    step();
    term_ok_i = 1'b0;
    chk("R8 still kept", busy_o, 1'b1);
    locked_i = 1'b0;
    step();
    chk("R8 release at unlock", busy_o, 1'b0);

    // R4 foreign cycle
    do_reset();
    grant_i = 1'b1; ext_ts_i = 1'b1;
    step();
    ext_ts_i = 1'b0; req_pend_i = 1'b1; #1;
    chk("R4 foreign open", start_o, 1'b0);
    term_ok_i = 1'b1;
    step();
    term_ok_i = 1'b0; #1;
    chk("R4 foreign closed", start_o, 1'b1);
    req_pend_i = 1'b0;

    // R1 gated edge keeps idle
    do_reset();
    clk_en_i = 1'b0; req_pend_i = 1'b1; grant_i = 1'b1;
    step();
    chk("R1 gated stays idle", start_o, 1'b1);
    clk_en_i = 1'b1;
    step();
    chk("R1 enabled advances", start_o, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule